// File: doc/BRIEF.md
# Keyed-Clear Watchdog with System Control Register

This block is a timeout watchdog for a small microcontroller, together with the system control register that arms it. A slow single-cycle tick, nominally 4 Hz, advances a small counter. While the watchdog is enabled, eight ticks without service make the counter reach its limit. The block then raises a system reset for one clock. Eight ticks at 4 Hz span the nominal 2-second service window.

Firmware services the watchdog by writing a two-value key to the watchdog register. The first value is 0x0A and the second is 0x03, with no other write to that register between them. Reading the watchdog register returns the live count. The enable bit is sticky: firmware can set it but cannot clear it, and the watchdog reset does not clear it either. Only the power-on reset input `por_ni` clears it.

The control register also holds four more bits. A sleep request bit produces a one-cycle sleep-entry pulse. That pulse is gated by a separately stored sleep-unlock bit. Two enable bits are forwarded to the reset logic elsewhere in the chip: one for the bus-error reset and one for resetting the port configuration.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, both registers read 0 and every output is 0. The control register is at address 0 and the watchdog register is at address 1. Any other address reads 0.
- R2: While the enable bit is 0, tick_i is ignored and the count stays at 0.
- R3: While enabled, each tick_i cycle adds one to the count. A read of address 1 returns the count in bits [3:0], with all other bits 0.
- R4: When the count reaches 8, wdt_rst_o is 1 for exactly that one cycle. In the next cycle several things hold:
  - The count is 0.
  - The unlock bit and both reset-enable bits are 0.
  - The enable bit is still 1.
- R5: A write of 0x0A to address 1, followed by a next write of 0x03 to address 1, sets the count to 0 from the cycle after the 0x03 write. This clear wins over a tick in the same cycle.
- R6: The key sequence is cancelled by a write to address 1 of any value other than 0x0A or 0x03 between the two key writes. The count is then not cleared. A 0x03 write with no 0x0A before it has no effect. Writes to other addresses do not cancel the sequence.
- R7: A write of 0x0A always arms the sequence, even when the previous write was also 0x0A. So 0x0A, 0x0A, 0x03 clears the count.
- R8: Writing 1 to control bit 2 sets the enable bit, and writing 0 to it has no effect. The enable bit survives rst_ni and the watchdog reset, and is cleared only by por_ni.
- R9: Control bit 0 is the sleep request and always reads 0. A control write with bit 0 set, made while the stored unlock bit (control bit 1) is 1, makes sleep_o 1 for the following cycle only. With the unlock bit at 0, there is no pulse.
- R10: Control bit 3 (bus-error reset enable) and control bit 4 (port-configuration reset enable) are plain read/write bits. They drive buserr_rst_en_o and portcfg_rst_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset; does not clear the enable bit |
| por_ni | input | 1 | Active-low asynchronous power-on reset; clears everything |
| tick_i | input | 1 | Single-cycle watchdog tick |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| wdt_rst_o | output | 1 | One-cycle watchdog timeout reset |
| sleep_o | output | 1 | One-cycle sleep-entry pulse |
| wdt_en_o | output | 1 | Sticky watchdog enable |
| buserr_rst_en_o | output | 1 | Bus-error reset enable |
| portcfg_rst_en_o | output | 1 | Port-configuration reset enable |

## Verification
The counting and clearing properties assume that tick_i and wr_i change only between clock edges. They also assume that reset inputs are released while no write or tick is pending. The bench drives all inputs on the falling edge and releases resets while the bus is idle.

The sleep property relates every pulse to a control write with bit 0 set in the cycle before. This keeps it valid even under back-to-back writes, which the bench never issues. The key sweep walks all 256 values through the position between the two key writes. The expected count is computed from the value alone.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned CTRL_SLEEP   = 0;
  localparam int unsigned CTRL_UNLOCK  = 1;
  localparam int unsigned CTRL_WDT_EN  = 2;
  localparam int unsigned CTRL_BUS_EN  = 3;
  localparam int unsigned CTRL_PORT_EN = 4;

  typedef struct packed {
    logic port_en;
    logic bus_en;
    logic wdt_en;
    logic unlock;
  } ctrl_t;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq #(
  parameter int unsigned DATA_W   = 8,
  parameter logic [7:0]  KEY_ARM  = 8'h0A,
  parameter logic [7:0]  KEY_FIRE = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              armed_o,
  output logic              clear_o
);
  import keyed_wdt_pkg::*;

  localparam logic [DATA_W-1:0] ARM_V  = DATA_W'(KEY_ARM);
  localparam logic [DATA_W-1:0] FIRE_V = DATA_W'(KEY_FIRE);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (soft_clr_i)          state_d = KEY_IDLE;
    else if (wr_i) begin
      if (wdata_i == ARM_V)  state_d = KEY_ARMED;
      else                   state_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == KEY_ARMED);
  assign clear_o = wr_i && armed_o && (wdata_i == FIRE_V);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned TIMEOUT = 8,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign timeout_o = (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || clear_i || timeout_o) cnt_d = '0;
    else if (tick_i)                   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/kwd_ctrl_reg.sv
module kwd_ctrl_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  por_ni,
  input  logic                  soft_clr_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output keyed_wdt_pkg::ctrl_t  ctrl_o,
  output logic                  sleep_o
);
  import keyed_wdt_pkg::*;

  logic en_q;
  logic unlock_q, bus_q, port_q, sleep_q;

  // sticky enable: only power-on reset clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                        en_q <= 1'b0;
    else if (wr_i && wdata_i[CTRL_WDT_EN]) en_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      bus_q    <= 1'b0;
      port_q   <= 1'b0;
      sleep_q  <= 1'b0;
    end else if (soft_clr_i) begin
      unlock_q <= 1'b0;
      bus_q    <= 1'b0;
      port_q   <= 1'b0;
      sleep_q  <= 1'b0;
    end else begin
      sleep_q <= wr_i && wdata_i[CTRL_SLEEP] && unlock_q;
      if (wr_i) begin
        unlock_q <= wdata_i[CTRL_UNLOCK];
        bus_q    <= wdata_i[CTRL_BUS_EN];
        port_q   <= wdata_i[CTRL_PORT_EN];
      end
    end
  end

  assign ctrl_o.wdt_en  = en_q;
  assign ctrl_o.unlock  = unlock_q;
  assign ctrl_o.bus_en  = bus_q;
  assign ctrl_o.port_en = port_q;
  assign sleep_o        = sleep_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned TIMEOUT   = 8,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned WDT_ADDR  = 1,
  parameter logic [7:0]  KEY_ARM   = 8'h0A,
  parameter logic [7:0]  KEY_FIRE  = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o,
  output logic              sleep_o,
  output logic              wdt_en_o,
  output logic              buserr_rst_en_o,
  output logic              portcfg_rst_en_o
);
  import keyed_wdt_pkg::*;

  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] WDT_A  = ADDR_W'(WDT_ADDR);

  logic             sys_rst_n;
  logic             ctrl_wr, wdt_wr;
  logic             key_clear, armed_q, timeout;
  logic [CNT_W-1:0] cnt_q;
  ctrl_t            ctrl;

  assign sys_rst_n = rst_ni & por_ni;
  assign ctrl_wr   = wr_i && (addr_i == CTRL_A);
  assign wdt_wr    = wr_i && (addr_i == WDT_A);

  kwd_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .por_ni     (por_ni),
    .soft_clr_i (timeout),
    .wr_i       (ctrl_wr),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl),
    .sleep_o    (sleep_o)
  );

  kwd_key_seq #(.DATA_W(DATA_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .soft_clr_i (timeout),
    .wr_i       (wdt_wr),
    .wdata_i    (wdata_i),
    .armed_o    (armed_q),
    .clear_o    (key_clear)
  );

  kwd_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (sys_rst_n),
    .en_i      (ctrl.wdt_en),
    .tick_i    (tick_i),
    .clear_i   (key_clear),
    .cnt_o     (cnt_q),
    .timeout_o (timeout)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) begin
      rdata_o[CTRL_UNLOCK]  = ctrl.unlock;
      rdata_o[CTRL_WDT_EN]  = ctrl.wdt_en;
      rdata_o[CTRL_BUS_EN]  = ctrl.bus_en;
      rdata_o[CTRL_PORT_EN] = ctrl.port_en;
    end else if (addr_i == WDT_A) begin
      rdata_o[CNT_W-1:0] = cnt_q;
    end
  end

  assign wdt_rst_o        = timeout;
  assign wdt_en_o         = ctrl.wdt_en;
  assign buserr_rst_en_o  = ctrl.bus_en;
  assign portcfg_rst_en_o = ctrl.port_en;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned TIMEOUT   = 8,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned WDT_ADDR  = 1,
  parameter logic [7:0]  KEY_FIRE  = 8'h03,
  localparam int unsigned CNT_W    = $clog2(TIMEOUT + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wdt_rst_o,
  input logic              sleep_o,
  input logic              wdt_en_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              armed_i
);
  a_r4_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    cnt_i <= CNT_W'(TIMEOUT));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    wdt_rst_o |=> !wdt_rst_o);

  a_r2_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !wdt_en_o |-> cnt_i == '0);

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wdt_en_o && tick_i && !wr_i && !wdt_rst_o) |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  a_r5_key_clear: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_i && addr_i == ADDR_W'(WDT_ADDR) && wdata_i == DATA_W'(KEY_FIRE) && armed_i)
    |=> cnt_i == '0);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!por_ni)
    wdt_en_o |=> wdt_en_o);

  a_r9_sleep_cause: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    sleep_o |-> $past(wr_i && addr_i == ADDR_W'(CTRL_ADDR) && wdata_i[0]));
endmodule

bind keyed_wdt kwd_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT),
  .CTRL_ADDR(CTRL_ADDR), .WDT_ADDR(WDT_ADDR), .KEY_FIRE(KEY_FIRE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .tick_i(tick_i),
  .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .wdt_rst_o(wdt_rst_o),
  .sleep_o(sleep_o), .wdt_en_o(wdt_en_o), .cnt_i(cnt_q), .armed_i(armed_q)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_WDT  = 2'd1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, por_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wdt_rst, sleep, wdt_en, bus_en, port_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  keyed_wdt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .wdt_rst_o(wdt_rst), .sleep_o(sleep), .wdt_en_o(wdt_en),
    .buserr_rst_en_o(bus_en), .portcfg_rst_en_o(port_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic key_clear();
    wr_reg(A_WDT, 8'h0A);
    wr_reg(A_WDT, 8'h03);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v;
    int exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);

    // R1
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_WDT, v);  chk("R1 wdt", v, 0);
    rd(2'd3, v);   chk("R1 unused addr", v, 0);
    chk("R1 outputs", {wdt_rst, sleep, wdt_en, bus_en, port_en}, 0);

    // R2
    for (int i = 0; i < 12; i++) do_tick();
    rd(A_WDT, v); chk("R2 disabled count", v, 0);

    // R10
    wr_reg(A_CTRL, 8'h18);
    rd(A_CTRL, v); chk("R10 readback", v, 8'h18);
    chk("R10 outs set", {bus_en, port_en}, 2'b11);
    wr_reg(A_CTRL, 8'h08);
    chk("R10 outs bus only", {bus_en, port_en}, 2'b10);
    wr_reg(A_CTRL, 8'h00);
    chk("R10 outs clear", {bus_en, port_en}, 0);

    // R9
    wr_reg(A_CTRL, 8'h01);
    chk("R9 locked no pulse", sleep, 0);
    rd(A_CTRL, v); chk("R9 sleep reads 0 locked", v, 0);
    wr_reg(A_CTRL, 8'h02);
    wr_reg(A_CTRL, 8'h03);
    chk("R9 pulse", sleep, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", sleep, 0);
    rd(A_CTRL, v); chk("R9 sleep reads 0", v, 8'h02);

    // enable
    wr_reg(A_CTRL, 8'h04);
    rd(A_CTRL, v); chk("R8 enable set", v, 8'h04);

    // R3 / R5 sweep
    for (int n = 0; n < 8; n++) begin
      key_clear();
      for (int t = 0; t < n; t++) do_tick();
      rd(A_WDT, v); chk("R3 count", v, n);
      chk("R3 no timeout", wdt_rst, 0);
      key_clear();
      rd(A_WDT, v); chk("R5 key clear", v, 0);
    end

    // R5 clear beats coincident tick
    key_clear();
    do_tick(); do_tick(); do_tick();
    wr_reg(A_WDT, 8'h0A);
    @(negedge clk);
    addr = A_WDT; wdata = 8'h03; wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    rd(A_WDT, v); chk("R5 clear over tick", v, 0);

    // R6 / R7 sweep over middle value
    for (int m = 0; m < 256; m++) begin
      key_clear();
      do_tick();
      wr_reg(A_WDT, 8'h0A);
      wr_reg(A_WDT, 8'(m));
      wr_reg(A_WDT, 8'h03);
      exp = (m == 8'h0A || m == 8'h03) ? 0 : 1;
      rd(A_WDT, v);
      chk((m == 8'h0A) ? "R7 rearm" : "R6 interrupted", v, exp);
    end

    // R6 lone fire value
    key_clear(); do_tick(); do_tick();
    wr_reg(A_WDT, 8'h03);
    rd(A_WDT, v); chk("R6 lone 0x03", v, 2);

    // R6 other-address write does not cancel
    wr_reg(A_WDT, 8'h0A);
    wr_reg(A_CTRL, 8'h04);
    wr_reg(A_WDT, 8'h03);
    rd(A_WDT, v); chk("R6 ctrl write between", v, 0);

    // R8 write 0 has no effect
    wr_reg(A_CTRL, 8'h00);
    chk("R8 write 0 kept", wdt_en, 1);

    // R4 timeout
    wr_reg(A_CTRL, 8'h1E);
    key_clear();
    for (int t = 0; t < 7; t++) do_tick();
    rd(A_WDT, v); chk("R4 count 7", v, 7);
    chk("R4 no rst at 7", wdt_rst, 0);
    do_tick();
    chk("R4 rst pulse", wdt_rst, 1);
    rd(A_WDT, v); chk("R4 count 8", v, 8);
    @(negedge clk);
    chk("R4 rst one cycle", wdt_rst, 0);
    rd(A_WDT, v); chk("R4 count cleared", v, 0);
    rd(A_CTRL, v); chk("R4 ctrl after timeout", v, 8'h04);
    chk("R4 outs after timeout", {wdt_en, bus_en, port_en}, 3'b100);

    // R8 system reset keeps enable, por clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 survives rst_ni", wdt_en, 1);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    chk("R8 por clears", wdt_en, 0);
    do_tick();
    rd(A_WDT, v); chk("R2 after por", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule